// File: doc/BRIEF.md
# Quadrature Input Decoder Front-End

This block sits between the encoder pins of one counter channel and the counter register. It takes the raw A, B and index pins and resynchronises them to the core clock. It then turns their transitions into single-cycle count-up and count-down strobes. The counter register that consumes these strobes is outside this block.

A 2-bit function field picks how edges are counted. Code 0 is pulse/direction. Code 1 is quadrature at one count per cycle, code 2 is two counts per cycle, and code 3 is four counts per cycle. Counting only happens while the A/B enable input is high.

The block keeps a direction flag that tracks the sensed motion. It also keeps a sticky noise-error flag, which is set when A and B both change in the same sample and stays set until a clear input is pulsed. The index pin yields a one-cycle event each time it becomes active. A polarity bit chooses whether active means high or low. An optional synchronous mode also requires A and B to both be high before the event can fire. That mode is only honoured when a quadrature function is selected.

Top module: `qdec_front`

## Requirements
- R1: With `func_sel` = 0 (pulse/direction), each rising edge of A gives one strobe: `cnt_up` if B is high at that sample, `cnt_dn` if B is low. A falling edges and all B edges give no strobe.
- R2: With `func_sel` = 1 (x1), a rising edge of A while B is low gives `cnt_up`, and a falling edge of A while B is low gives `cnt_dn`. No other transition gives a strobe.
- R3: With `func_sel` = 2 (x2), every single-input edge of A gives a strobe, and B edges give none. The forward A/B sequence is 00→10→11→01→00, with bit order {A,B}; forward steps give `cnt_up` and backward steps give `cnt_dn`.
- R4: With `func_sel` = 3 (x4), every single-input edge of A or of B gives one strobe, with the direction taken from the forward sequence of R3.
- R5: While `ab_en` is low, no count strobe is produced and `dir_up` holds its value.
- R6: A sample in which A and B both change gives no strobe. If `ab_en` is high, it sets `noise_err`.
- R7: `noise_err` stays at 1 until a cycle with `err_clr` high clears it. A new noise sample in the same cycle wins over the clear.
- R8: `dir_up` is 1 for forward (up) and 0 for backward (down). It resets to 1. In quadrature functions it follows every valid single-input step. In pulse/direction it takes the value of B at each rising edge of A.
- R9: `idx_evt` pulses for exactly one cycle each time the index becomes active. Active is high when `idx_pol` = 1 and low when `idx_pol` = 0. Holding the index active or releasing it gives no further event.
- R10: `sync_active` is 1 only when `idx_sync_req` = 1 and `func_sel` ≠ 0. While it is 1, the index event fires only at the first sample in which the index is active and A and B are both high. In pulse/direction mode, the index event ignores A and B.
- R11: After reset, all strobes and `noise_err` are 0 and `dir_up` is 1. A pin change that lands before clock edge k produces its strobe in the cycle after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_a | input | 1 | Raw encoder A input |
| pin_b | input | 1 | Raw encoder B input |
| pin_idx | input | 1 | Raw index input |
| func_sel | input | 2 | Counting function: 0 pulse/dir, 1 x1, 2 x2, 3 x4 |
| ab_en | input | 1 | Enables counting on A/B |
| idx_pol | input | 1 | Index active level: 1 high, 0 low |
| idx_sync_req | input | 1 | Requests synchronous index qualification |
| err_clr | input | 1 | Clears the noise-error flag |
| cnt_up | output | 1 | One-cycle count-up strobe |
| cnt_dn | output | 1 | One-cycle count-down strobe |
| idx_evt | output | 1 | One-cycle index event |
| dir_up | output | 1 | Current direction: 1 up, 0 down |
| noise_err | output | 1 | Sticky noise-error flag |
| sync_active | output | 1 | Synchronous index mode in effect |

## Verification
The bench walks one full forward and one full backward encoder cycle in every function. This catches a decoder that counts B edges in x2, or that counts the wrong A edge in x1. Such a decoder would over-count or count in the wrong direction at the steps where only some edges should count.

A simultaneous A/B change is driven both with the enable high and with it low. This exposes a decoder that counts a noisy sample, or one that flags noise while disabled.

The index is driven with both polarities and held active across samples, so a level-triggered implementation would repeat the event. Synchronous mode is requested in pulse/direction mode to show that the request is dropped there; a design that kept it would never fire the index event with A and B low.

// File: rtl/qdec_front.sv
module qdec_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_idx,
  input  logic [1:0] func_sel,
  input  logic       ab_en,
  input  logic       idx_pol,
  input  logic       idx_sync_req,
  input  logic       err_clr,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       idx_evt,
  output logic       dir_up,
  output logic       noise_err,
  output logic       sync_active
);
  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [1:0] F_PULSE = 2'd0;
  localparam logic [1:0] F_X1    = 2'd1;
  localparam logic [1:0] F_X2    = 2'd2;

  logic [TOP:0] sa, sb, si;
  logic a_s, b_s, i_s, a_q, b_q, qual_q;
  logic da, db, step, noise, fwd, bwd, rise_a;
  logic up_nx, dn_nx, act, qual;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
      si <= '0;
    end else begin
      sa <= {sa[TOP-1:0], pin_a};
      sb <= {sb[TOP-1:0], pin_b};
      si <= {si[TOP-1:0], pin_idx};
    end
  end

  assign a_s = sa[TOP];
  assign b_s = sb[TOP];
  assign i_s = si[TOP];

  assign da     = a_s ^ a_q;
  assign db     = b_s ^ b_q;
  assign step   = da ^ db;
  assign noise  = da & db;
  assign fwd    = step & (da ? (a_s ^ b_s) : ~(a_s ^ b_s));
  assign bwd    = step & ~fwd;
  assign rise_a = da & ~db & a_s;

  always_comb begin
    up_nx = 1'b0;
    dn_nx = 1'b0;
    case (func_sel)
      F_PULSE: begin
        up_nx = rise_a & b_s;
        dn_nx = rise_a & ~b_s;
      end
      F_X1: begin
        up_nx = rise_a & ~b_s;
        dn_nx = da & ~db & ~a_s & ~b_s;
      end
      F_X2: begin
        up_nx = da & fwd;
        dn_nx = da & bwd;
      end
      default: begin
        up_nx = fwd;
        dn_nx = bwd;
      end
    endcase
  end

  assign sync_active = idx_sync_req & (func_sel != F_PULSE);
  assign act  = idx_pol ? i_s : ~i_s;
  assign qual = act & (~sync_active | (a_s & b_s));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      qual_q    <= 1'b1;
      cnt_up    <= 1'b0;
      cnt_dn    <= 1'b0;
      idx_evt   <= 1'b0;
      dir_up    <= 1'b1;
      noise_err <= 1'b0;
    end else begin
      a_q     <= a_s;
      b_q     <= b_s;
      qual_q  <= qual;
      cnt_up  <= ab_en & up_nx;
      cnt_dn  <= ab_en & dn_nx;
      idx_evt <= qual & ~qual_q;
      if (ab_en) begin
        if (func_sel == F_PULSE) begin
          if (rise_a) dir_up <= b_s;
        end else if (step) begin
          dir_up <= fwd;
        end
      end
      if (ab_en & noise) noise_err <= 1'b1;
      else if (err_clr)  noise_err <= 1'b0;
    end
  end
endmodule

module qdec_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] func_sel,
  input logic       ab_en,
  input logic       err_clr,
  input logic       cnt_up,
  input logic       cnt_dn,
  input logic       dir_up,
  input logic       noise_err,
  input logic       sync_active
);
  // R5
  gated_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up || cnt_dn) |-> $past(ab_en));
  // R5
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ab_en) |-> $stable(dir_up));
  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noise_err) |-> $past(ab_en));
  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(noise_err) && !$past(err_clr)) |-> noise_err);
  // R2
  x1_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(func_sel) == 2'd1 && $past(cnt_up)) |-> !cnt_up);
  // R10
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_active |-> func_sel != 2'd0);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));
endmodule

bind qdec_front qdec_front_chk chk_i (
  .clk(clk), .rst_n(rst_n), .func_sel(func_sel), .ab_en(ab_en),
  .err_clr(err_clr), .cnt_up(cnt_up), .cnt_dn(cnt_dn), .dir_up(dir_up),
  .noise_err(noise_err), .sync_active(sync_active)
);

// File: tb/qdec_front_tb_top.sv
module qdec_front_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0, pin_idx = 1'b0;
  logic [1:0] func_sel = 2'd3;
  logic ab_en = 1'b1, idx_pol = 1'b1, idx_sync_req = 1'b0, err_clr = 1'b0;
  logic cnt_up, cnt_dn, idx_evt, dir_up, noise_err, sync_active;
  int total = 0, bad = 0;
  int nu, nd, ne;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qdec_front dut_i (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx),
    .func_sel(func_sel), .ab_en(ab_en), .idx_pol(idx_pol),
    .idx_sync_req(idx_sync_req), .err_clr(err_clr), .cnt_up(cnt_up),
    .cnt_dn(cnt_dn), .idx_evt(idx_evt), .dir_up(dir_up),
    .noise_err(noise_err), .sync_active(sync_active)
  );

  // {func[1:0], a, b, up[1:0], dn[1:0], dir}
  localparam int NV = 32;
  localparam logic [8:0] VEC [NV] = '{
    {2'd3,1'b1,1'b0,2'd1,2'd0,1'b1}, {2'd3,1'b1,1'b1,2'd1,2'd0,1'b1},
    {2'd3,1'b0,1'b1,2'd1,2'd0,1'b1}, {2'd3,1'b0,1'b0,2'd1,2'd0,1'b1},
    {2'd3,1'b0,1'b1,2'd0,2'd1,1'b0}, {2'd3,1'b1,1'b1,2'd0,2'd1,1'b0},
    {2'd3,1'b1,1'b0,2'd0,2'd1,1'b0}, {2'd3,1'b0,1'b0,2'd0,2'd1,1'b0},
    {2'd2,1'b1,1'b0,2'd1,2'd0,1'b1}, {2'd2,1'b1,1'b1,2'd0,2'd0,1'b1},
    {2'd2,1'b0,1'b1,2'd1,2'd0,1'b1}, {2'd2,1'b0,1'b0,2'd0,2'd0,1'b1},
    {2'd2,1'b0,1'b1,2'd0,2'd0,1'b0}, {2'd2,1'b1,1'b1,2'd0,2'd1,1'b0},
    {2'd2,1'b1,1'b0,2'd0,2'd0,1'b0}, {2'd2,1'b0,1'b0,2'd0,2'd1,1'b0},
    {2'd1,1'b1,1'b0,2'd1,2'd0,1'b1}, {2'd1,1'b1,1'b1,2'd0,2'd0,1'b1},
    {2'd1,1'b0,1'b1,2'd0,2'd0,1'b1}, {2'd1,1'b0,1'b0,2'd0,2'd0,1'b1},
    {2'd1,1'b0,1'b1,2'd0,2'd0,1'b0}, {2'd1,1'b1,1'b1,2'd0,2'd0,1'b0},
    {2'd1,1'b1,1'b0,2'd0,2'd0,1'b0}, {2'd1,1'b0,1'b0,2'd0,2'd1,1'b0},
    {2'd0,1'b0,1'b1,2'd0,2'd0,1'b0}, {2'd0,1'b1,1'b1,2'd1,2'd0,1'b1},
    {2'd0,1'b0,1'b1,2'd0,2'd0,1'b1}, {2'd0,1'b1,1'b1,2'd1,2'd0,1'b1},
    {2'd0,1'b1,1'b0,2'd0,2'd0,1'b1}, {2'd0,1'b0,1'b0,2'd0,2'd0,1'b1},
    {2'd0,1'b1,1'b0,2'd0,2'd1,1'b0}, {2'd0,1'b0,1'b0,2'd0,2'd0,1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    nu = 0; nd = 0; ne = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      nu += int'(cnt_up);
      nd += int'(cnt_dn);
      ne += int'(idx_evt);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic ix);
    @(negedge clk);
    pin_a = a; pin_b = b; pin_idx = ix;
    settle();
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 up", cnt_up, 0);
    check("R11 dn", cnt_dn, 0);
    check("R11 err", noise_err, 0);
    check("R11 dir", dir_up, 1);
    check("R10 sync idle", sync_active, 0);

    // R11 latency: strobe appears in the cycle after the third edge
    @(negedge clk);
    pin_a = 1'b1;
    @(negedge clk); check("R11 lat0", cnt_up, 0);
    @(negedge clk); check("R11 lat1", cnt_up, 0);
    @(negedge clk); check("R11 lat2", cnt_up, 1);
    @(negedge clk); check("R11 lat3", cnt_up, 0);
    pin_a = 1'b0;
    settle();

    // R1 R2 R3 R4 R8 vector table
    for (int v = 0; v < NV; v++) begin
      func_sel = VEC[v][8:7];
      drive(VEC[v][6], VEC[v][5], 1'b0);
      check($sformatf("R1-4 up v%0d", v), nu, int'(VEC[v][4:3]));
      check($sformatf("R1-4 dn v%0d", v), nd, int'(VEC[v][2:1]));
      check($sformatf("R8 dir v%0d", v), dir_up, int'(VEC[v][0]));
    end

    // R5 disabled: no counts, direction held
    func_sel = 2'd3;
    ab_en = 1'b0;
    drive(1'b1, 1'b0, 1'b0);
    check("R5 up", nu, 0);
    drive(1'b1, 1'b1, 1'b0);
    check("R5 up2", nu, 0);
    check("R5 dir", dir_up, 0);
    // R6 noise while disabled does not set the flag
    drive(1'b0, 1'b0, 1'b0);
    check("R6 noerr disabled", noise_err, 0);
    ab_en = 1'b1;
    settle();

    // R6 noise: both change, no count, flag set
    drive(1'b1, 1'b1, 1'b0);
    check("R6 up", nu, 0);
    check("R6 dn", nd, 0);
    check("R6 err", noise_err, 1);
    // R7 sticky
    drive(1'b0, 1'b1, 1'b0);
    check("R7 count ok", nu, 1);
    check("R7 still set", noise_err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R7 cleared", noise_err, 0);
    drive(1'b0, 1'b0, 1'b0);

    // R9 positive polarity
    idx_pol = 1'b1;
    drive(1'b0, 1'b0, 1'b1);
    check("R9 pos rise", ne, 1);
    drive(1'b0, 1'b0, 1'b1);
    check("R9 pos hold", ne, 0);
    drive(1'b0, 1'b0, 1'b0);
    check("R9 pos release", ne, 0);
    // R9 negative polarity
    idx_pol = 1'b0;
    settle();
    drive(1'b0, 1'b0, 1'b1);
    check("R9 neg inactive", ne, 0);
    drive(1'b0, 1'b0, 1'b0);
    check("R9 neg active", ne, 1);
    drive(1'b0, 1'b0, 1'b1);
    idx_pol = 1'b1;
    settle();
    drive(1'b0, 1'b0, 1'b0);

    // R10 synchronous index in x4
    idx_sync_req = 1'b1;
    @(negedge clk);
    check("R10 sync on", sync_active, 1);
    drive(1'b0, 1'b0, 1'b1);
    check("R10 blocked", ne, 0);
    drive(1'b1, 1'b0, 1'b1);
    check("R10 A only", ne, 0);
    drive(1'b1, 1'b1, 1'b1);
    check("R10 fires", ne, 1);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0);

    // R10 pulse/direction forces synchronous mode off
    func_sel = 2'd0;
    @(negedge clk);
    check("R10 forced off", sync_active, 0);
    drive(1'b0, 1'b0, 1'b1);
    check("R10 pulse idx", ne, 1);
    drive(1'b0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule